// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a 64-byte bank of read-only configuration registers once after reset. If the strap input `strap_use_rom` is high when reset is released, the block reads the image from an external 3-wire serial EEPROM as 32 sixteen-bit words. It generates the chip select, the serial clock and the command bit stream itself. It writes each word into the register bank as two bytes.

If the strap is low at reset release, the EEPROM is not touched. The block then writes 64 built-in default bytes, one per clock.

Until the bank is complete, a host request for configuration space receives a retry response. After that, the `load_done` output stays high until the next reset.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: With the strap high at reset release, the block performs 32 read transactions for word addresses 0, 1, …, 31 in that order. Each transaction begins with the 9 command bits: a 1, then 1, then 0, then the 6-bit word address MSB first.
- R2: `rom_sck` has a period of 2·CLK_DIV clocks, and each high phase lasts exactly CLK_DIV clocks. `rom_mosi` changes only while `rom_sck` is low. `rom_miso` is sampled on the rising edge of `rom_sck`.
- R3: `rom_cs` is active high and stays high for a whole transaction. Between transactions it is low for at least 2·CLK_DIV clocks. `rom_sck` is low whenever `rom_cs` is low.
- R4: After the command, the first returned bit (a dummy) is discarded. The next 16 bits form the word, MSB first. Word n is written as its low byte to address 2n, and its high byte to address 2n+1 on the following clock.
- R5: With the strap low at reset release, `rom_cs` never rises. The block writes addresses 0 to 63 on 64 consecutive clocks, with data equal to {2'b00, address} XOR DEF_XOR.
- R6: `load_done` is low from reset. It rises on the clock after the write to address 63 and then stays high. Exactly 64 writes occur per load, and there are none after `load_done`.
- R7: `cfg_retry` is high exactly when `cfg_req` is high and `load_done` is low.
- R8: The strap is sampled only at reset release. Changing it later does not alter the source of the data or the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_use_rom | input | 1 | High: load from EEPROM; low: load defaults |
| rom_cs | output | 1 | EEPROM chip select, active high |
| rom_sck | output | 1 | EEPROM serial clock |
| rom_mosi | output | 1 | Command bits to the EEPROM |
| rom_miso | input | 1 | Data bits from the EEPROM |
| cfg_we | output | 1 | Register bank write strobe |
| cfg_addr | output | 6 | Register bank byte address |
| cfg_wdata | output | 8 | Register bank write data |
| load_done | output | 1 | Bank complete |
| cfg_req | input | 1 | Host configuration access request |
| cfg_retry | output | 1 | Retry response to the host |

## Verification
The register-bank write port, `load_done` and `cfg_retry` are decoded from the state register or from inputs. The bench therefore samples them on the falling clock edge of the same cycle. It expects `load_done` exactly one cycle after the write to address 63, and the second byte of a word one cycle after the first.

The EEPROM model reacts to the edges of `rom_sck`. It changes `rom_miso` on each falling edge once nine command bits have arrived, so the block's rising-edge sample lands a full half period after the change.

The serial-clock high time, the chip-select gap and the stability of `rom_mosi` are measured as run lengths of samples taken on falling clock edges.

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int CLK_DIV = 4,
  parameter logic [7:0] DEF_XOR = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_use_rom,
  output logic       rom_cs,
  output logic       rom_sck,
  output logic       rom_mosi,
  input  logic       rom_miso,
  output logic       cfg_we,
  output logic [5:0] cfg_addr,
  output logic [7:0] cfg_wdata,
  output logic       load_done,
  input  logic       cfg_req,
  output logic       cfg_retry
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int CMD_BITS = 9;
  localparam int LAST_BIT = CMD_BITS + 16;

  typedef enum logic [2:0] {S_BOOT, S_GAP, S_XFER, S_WR1, S_WR2, S_DEF, S_DONE} st_t;

  st_t         st;
  logic [DW-1:0] dcnt;
  logic [4:0]  bcnt;
  logic [1:0]  gcnt;
  logic [4:0]  waddr;
  logic [5:0]  idx;
  logic [15:0] sreg;
  logic        sck_q;
  logic        tick;
  logic [8:0]  cmd;

  assign tick = (dcnt == DW'(CLK_DIV - 1));
  assign cmd  = {3'b110, 1'b0, waddr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_BOOT; dcnt <= '0; bcnt <= '0; gcnt <= '0;
      waddr <= '0; idx <= '0; sreg <= '0; sck_q <= 1'b0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      case (st)
        S_BOOT: st <= strap_use_rom ? S_GAP : S_DEF;
        S_GAP: if (tick) begin
          if (gcnt == 2'd2) begin st <= S_XFER; bcnt <= '0; gcnt <= '0; end
          else gcnt <= gcnt + 1'b1;
        end
        S_XFER: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            if (bcnt > 5'(CMD_BITS)) sreg <= {sreg[14:0], rom_miso};
          end else begin
            sck_q <= 1'b0;
            if (bcnt == 5'(LAST_BIT)) st <= S_WR1;
            else bcnt <= bcnt + 1'b1;
          end
        end
        S_WR1: st <= S_WR2;
        S_WR2: if (waddr == 5'd31) st <= S_DONE;
               else begin waddr <= waddr + 1'b1; st <= S_GAP; end
        S_DEF: begin
          idx <= idx + 1'b1;
          if (idx == 6'd63) st <= S_DONE;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  assign rom_cs    = (st == S_XFER);
  assign rom_sck   = sck_q;
  assign rom_mosi  = (st == S_XFER && bcnt < 5'(CMD_BITS)) ? cmd[4'd8 - bcnt[3:0]] : 1'b0;
  assign cfg_we    = (st == S_WR1) || (st == S_WR2) || (st == S_DEF);
  assign cfg_addr  = (st == S_DEF) ? idx : {waddr, st == S_WR2};
  assign cfg_wdata = (st == S_DEF) ? ({2'b00, idx} ^ DEF_XOR) :
                     (st == S_WR2) ? sreg[15:8] : sreg[7:0];
  assign load_done = (st == S_DONE);
  assign cfg_retry = cfg_req && !load_done;

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sck && $past(rom_sck)) |-> $stable(rom_mosi));
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs |-> !rom_sck);
  p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR1) |=> (cfg_we && cfg_addr[0] && cfg_addr[5:1] == $past(cfg_addr[5:1])));
  p_def_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEF) |-> !rom_cs);
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  p_done_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !cfg_we);
  p_no_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !cfg_retry);
endmodule

// File: tb/tb_cfg_eeprom_loader.sv
module tb_cfg_eeprom_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam logic [7:0] XV = 8'h5A;

  logic clk = 0, rst_n = 0, strap = 1, miso = 0, req = 0;
  logic cs, sck, mosi, we, done, retry;
  logic [5:0] addr;
  logic [7:0] wdata;

  cfg_eeprom_loader #(.CLK_DIV(DIV), .DEF_XOR(XV)) dut (
    .clk(clk), .rst_n(rst_n), .strap_use_rom(strap), .rom_cs(cs), .rom_sck(sck),
    .rom_mosi(mosi), .rom_miso(miso), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .load_done(done), .cfg_req(req), .cfg_retry(retry));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  logic [15:0] mem [32];
  bit def_mode = 0;
  function automatic logic [7:0] exp_byte(input int a);
    if (def_mode) return 8'(a) ^ XV;
    return a[0] ? mem[a/2][15:8] : mem[a/2][7:0];
  endfunction

  // EEPROM model
  int mcnt = 0, mword = 0;
  logic [8:0] mcmd;
  logic [15:0] mdat;
  always @(negedge cs or negedge rst_n) begin mcnt = 0; miso = 0; end
  always @(negedge rst_n) mword = 0;
  always @(posedge sck) if (cs) begin
    if (mcnt < 9) mcmd = {mcmd[7:0], mosi};
    mcnt++;
    if (mcnt == 9) begin
      chk(mcmd == {3'b110, 6'(mword)}, "R1 command", mcmd, {3'b110, 6'(mword)});
      mdat = mem[mcmd[4:0]];
      mword++;
    end
  end
  always @(negedge sck) if (cs && mcnt >= 9) begin
    if (mcnt == 9) miso = 1'b0;
    else if (mcnt <= 25) miso = mdat[25 - mcnt];
    else miso = 1'b0;
  end

  // monitor
  int nexp = 0, hi_run = 0, lo_cs = 0;
  bit done_due = 0, prev_sck = 0, prev_mosi = 0, cs_seen_def = 0, saw_cs = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      nexp = 0; hi_run = 0; lo_cs = 0; done_due = 0; saw_cs = 0;
    end else begin
      if (done_due) begin chk(done === 1'b1, "R6 done timing", done, 1); done_due = 0; end
      chk(retry === (req && !done), "R7 retry", retry, req && !done);
      if (we) begin
        chk(!done, "R6 write after done", done, 0);
        chk(addr == 6'(nexp), def_mode ? "R5 addr order" : "R4 addr order", addr, nexp);
        chk(wdata == exp_byte(addr), def_mode ? "R5 default data" : "R4 word data", wdata, exp_byte(addr));
        if (addr == 6'd63) done_due = 1;
        nexp++;
      end
      if (def_mode && cs) cs_seen_def = 1;
      if (sck && prev_sck && mosi != prev_mosi) chk(0, "R2 mosi moved while sck high", mosi, prev_mosi);
      if (sck) hi_run++;
      else if (hi_run != 0) begin chk(hi_run == DIV, "R2 sck high time", hi_run, DIV); hi_run = 0; end
      if (!cs && sck) chk(0, "R3 sck with cs low", sck, 0);
      if (cs) begin
        if (saw_cs && lo_cs != 0) chk(lo_cs >= 2*DIV, "R3 cs gap", lo_cs, 2*DIV);
        lo_cs = 0; saw_cs = 1;
      end else lo_cs++;
      prev_sck = sck; prev_mosi = mosi;
    end
    req = $urandom_range(0, 1);
  end

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done === 1'b1, tag, done, 1);
    repeat (5) @(negedge clk);
    chk(nexp == 64, "R6 write count", nexp, 64);
    chk(done === 1'b1, "R6 done sticky", done, 1);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cs && !sck && !we && !done, "R6 reset state", {cs, sck, we, done}, 0);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (mem[i]) mem[i] = 16'($urandom);
    mem[0] = 16'h0000; mem[1] = 16'h8001; mem[31] = 16'hFFFF;
    @(negedge clk);
    do_reset();
    repeat (1500) @(negedge clk);
    chk(!done, "R6 done low mid-load", done, 0);
    do_reset();
    repeat (1000) @(negedge clk);
    strap = 0;  // R8: late strap change ignored
    wait_done("R1 rom load completes");
    strap = 1;

    foreach (mem[i]) mem[i] = 16'($urandom);
    mem[5] = 16'hAAAA; mem[6] = 16'h5555;
    do_reset();
    wait_done("R4 second rom load");

    def_mode = 1; cs_seen_def = 0; strap = 0;
    do_reset();
    repeat (10) @(negedge clk);
    strap = 1;  // R8
    wait_done("R5 default load completes");
    chk(!cs_seen_def, "R5 cs stayed low", cs_seen_def, 0);
    req = 1; #1;
    chk(!retry, "R7 no retry after done", retry, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule